// File: doc/BRIEF.md
# Hazard-Searchable Instruction Queue

This block is a two-entry queue of decoded instruction records. It sits between the front stage of a two-stage pipeline, which decodes instructions, and the back stage, which executes them. The front stage pushes records through a valid/ready enqueue port. The back stage sees the oldest record on a head port and retires it with a dequeue strobe. When the head is a branch whose condition value is zero, the back stage pulses the flush input, and every queued record is discarded.

A combinational lookup port takes a 5-bit register name and reports whether any record still in the queue will write that register. The front stage uses this to stall on read-after-write hazards. Within a cycle, the back-stage actions (head read, dequeue and flush) are applied first. The lookup and the enqueue then see the queue as those actions leave it. As a result, a retiring record cannot cause a false stall, and a record can be pushed into a slot that is freed in the same cycle.

Top module: `srch_fifo`

## Requirements
- R1: After reset the queue is empty: `head_vld_o`=0, `enq_rdy_o`=1, and `srch_hit_o`=0 for every key.
- R2: Records leave in arrival order. The capacity is 2. With two records held and no dequeue or flush, `enq_rdy_o`=0.
- R3: The kind is encoded as add=2'd0, branch-if-zero=2'd1, load=2'd2, store=2'd3. Kind, register field and both 32-bit value fields appear at the head unchanged.
- R4: `srch_hit_o`=1 when a held add or load record has a register field equal to `srch_key_i`.
- R5: A branch or store record never causes a hit, whatever its register field holds.
- R6: When `deq_i` is high and the queue is non-empty, the head record is excluded from the lookup in that same cycle.
- R7: `clr_i` discards all held records by the next cycle. In the cycle it is high, no held record causes a hit.
- R8: When the queue is full and `deq_i` is high, `enq_rdy_o`=1. The new record is placed behind the remaining one.
- R9: A record enqueued in the same cycle as `clr_i` is kept and becomes the only entry.
- R10: `deq_i` on an empty queue has no effect. `enq_vld_i` while `enq_rdy_o`=0 stores nothing.
- R11: The lookup never sees the record being enqueued in the same cycle. The hit appears from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_vld_i | input | 1 | Enqueue request |
| enq_rdy_o | output | 1 | Enqueue accepted this cycle |
| enq_kind_i | input | 2 | Record kind |
| enq_rd_i | input | 5 | Destination register field |
| enq_a_i | input | 32 | Operand 1, condition or store data |
| enq_b_i | input | 32 | Operand 2, target or address |
| head_vld_o | output | 1 | Queue not empty |
| head_kind_o | output | 2 | Head kind |
| head_rd_o | output | 5 | Head register field |
| head_a_o | output | 32 | Head first value |
| head_b_o | output | 32 | Head second value |
| deq_i | input | 1 | Retire head |
| clr_i | input | 1 | Flush all records |
| srch_key_i | input | 5 | Register name to look up |
| srch_hit_o | output | 1 | A pending write to the key exists |

## Verification
Two kinds of collision matter here: a lookup in the same cycle as a dequeue or flush, and an enqueue in the same cycle as a dequeue or flush. The bench holds the back-stage strobe and the lookup key or enqueue request together within one cycle. It samples `srch_hit_o` and `enq_rdy_o` in that cycle before the clock edge. It then checks the head contents after the edge to confirm which record survived and in what order.

// File: rtl/srch_fifo_pkg.sv
package srch_fifo_pkg;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    K_ADD   = 2'd0,
    K_BZ    = 2'd1,
    K_LOAD  = 2'd2,
    K_STORE = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [REG_W-1:0]  rd;
    logic [DATA_W-1:0] a;
    logic [DATA_W-1:0] b;
  } entry_t;
endpackage

// File: rtl/srch_fifo_ctrl.sv
module srch_fifo_ctrl #(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_vld_i,
  input  logic             deq_i,
  input  logic             clr_i,
  output logic             enq_rdy_o,
  output logic             enq_fire_o,
  output logic             head_vld_o,
  output logic [PW-1:0]    wr_idx_o,
  output logic [PW-1:0]    rd_idx_o,
  output logic [DEPTH-1:0] valid_mid_o
);
  logic [DEPTH-1:0] valid_q, valid_d, valid_mid;
  logic [PW-1:0]    rd_q, rd_d, wr_q, wr_d, rd_mid, wr_mid;
  logic             deq_fire;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Execute-side actions (deq, clr) resolve first; enq and search see the result.
  always_comb begin
    head_vld_o = valid_q[rd_q];
    deq_fire   = deq_i & head_vld_o & ~clr_i;
    rd_mid     = deq_fire ? nxt(rd_q) : rd_q;
    wr_mid     = clr_i ? rd_mid : wr_q;
    valid_mid  = clr_i ? '0 : valid_q;
    if (deq_fire) valid_mid[rd_q] = 1'b0;
    enq_rdy_o  = ~valid_mid[wr_mid];
    enq_fire_o = enq_vld_i & enq_rdy_o;
    valid_d    = valid_mid;
    if (enq_fire_o) valid_d[wr_mid] = 1'b1;
    wr_d       = enq_fire_o ? nxt(wr_mid) : wr_mid;
    rd_d       = rd_mid;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      rd_q    <= rd_d;
      wr_q    <= wr_d;
    end
  end

  assign wr_idx_o    = wr_mid;
  assign rd_idx_o    = rd_q;
  assign valid_mid_o = valid_mid;
endmodule

// File: rtl/srch_fifo_slots.sv
module srch_fifo_slots
  import srch_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [PW-1:0]        wr_idx_i,
  input  entry_t               wr_data_i,
  input  logic [PW-1:0]        rd_idx_i,
  output entry_t               rd_data_o,
  output entry_t [DEPTH-1:0]   slots_o
);
  entry_t [DEPTH-1:0] mem_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[i] <= '0;
      else if (wr_en_i && wr_idx_i == PW'(i))     mem_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign slots_o   = mem_q;
endmodule

// File: rtl/srch_fifo_search.sv
module srch_fifo_search
  import srch_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  entry_t [DEPTH-1:0] slots_i,
  input  logic   [DEPTH-1:0] valid_i,
  input  logic   [REG_W-1:0] key_i,
  output logic               hit_o
);
  logic [DEPTH-1:0] match;

  // Only kinds that write a register can create a hazard.
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = valid_i[i]
                    && (slots_i[i].kind == K_ADD || slots_i[i].kind == K_LOAD)
                    && (slots_i[i].rd == key_i);
  end

  assign hit_o = |match;
endmodule

// File: rtl/srch_fifo.sv
module srch_fifo
  import srch_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enq_vld_i,
  output logic        enq_rdy_o,
  input  logic [1:0]  enq_kind_i,
  input  logic [4:0]  enq_rd_i,
  input  logic [31:0] enq_a_i,
  input  logic [31:0] enq_b_i,
  output logic        head_vld_o,
  output logic [1:0]  head_kind_o,
  output logic [4:0]  head_rd_o,
  output logic [31:0] head_a_o,
  output logic [31:0] head_b_o,
  input  logic        deq_i,
  input  logic        clr_i,
  input  logic [4:0]  srch_key_i,
  output logic        srch_hit_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic               enq_fire;
  logic [PW-1:0]      wr_idx, rd_idx;
  logic [DEPTH-1:0]   valid_mid;
  entry_t             enq_ent, head_ent;
  entry_t [DEPTH-1:0] slots;

  assign enq_ent = '{kind: kind_e'(enq_kind_i), rd: enq_rd_i, a: enq_a_i, b: enq_b_i};

  srch_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enq_vld_i  (enq_vld_i),
    .deq_i      (deq_i),
    .clr_i      (clr_i),
    .enq_rdy_o  (enq_rdy_o),
    .enq_fire_o (enq_fire),
    .head_vld_o (head_vld_o),
    .wr_idx_o   (wr_idx),
    .rd_idx_o   (rd_idx),
    .valid_mid_o(valid_mid)
  );

  srch_fifo_slots #(.DEPTH(DEPTH)) u_slots (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (enq_fire),
    .wr_idx_i (wr_idx),
    .wr_data_i(enq_ent),
    .rd_idx_i (rd_idx),
    .rd_data_o(head_ent),
    .slots_o  (slots)
  );

  srch_fifo_search #(.DEPTH(DEPTH)) u_search (
    .slots_i(slots),
    .valid_i(valid_mid),
    .key_i  (srch_key_i),
    .hit_o  (srch_hit_o)
  );

  assign head_kind_o = head_ent.kind;
  assign head_rd_o   = head_ent.rd;
  assign head_a_o    = head_ent.a;
  assign head_b_o    = head_ent.b;
endmodule

// File: rtl/srch_fifo_chk.sv
module srch_fifo_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        enq_vld_i,
  input logic        enq_rdy_o,
  input logic [1:0]  enq_kind_i,
  input logic [4:0]  enq_rd_i,
  input logic [31:0] enq_a_i,
  input logic [31:0] enq_b_i,
  input logic        head_vld_o,
  input logic [1:0]  head_kind_o,
  input logic [4:0]  head_rd_o,
  input logic [31:0] head_a_o,
  input logic [31:0] head_b_o,
  input logic        deq_i,
  input logic        clr_i,
  input logic [4:0]  srch_key_i,
  input logic        srch_hit_o
);
  // R1
  empty_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_vld_o |-> !srch_hit_o);

  // R2
  empty_accepts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_vld_o |-> enq_rdy_o);

  // R8
  deq_frees_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_vld_o && deq_i) |-> enq_rdy_o);

  // R7
  clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(enq_vld_i && enq_rdy_o)) |=> !head_vld_o);

  // R3
  head_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_vld_o && !deq_i && !clr_i) |=>
      (head_vld_o && $stable(head_kind_o) && $stable(head_rd_o)
       && $stable(head_a_o) && $stable(head_b_o)));

  // R9
  clear_enq_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && enq_vld_i) |=> head_vld_o);
endmodule

bind srch_fifo srch_fifo_chk chk_i (.*);

// File: tb/srch_fifo_tb_top.sv
module srch_fifo_tb_top;
  localparam time CLK_P = 20ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enq_vld_i = 1'b0;
  logic        enq_rdy_o;
  logic [1:0]  enq_kind_i = '0;
  logic [4:0]  enq_rd_i = '0;
  logic [31:0] enq_a_i = '0;
  logic [31:0] enq_b_i = '0;
  logic        head_vld_o;
  logic [1:0]  head_kind_o;
  logic [4:0]  head_rd_o;
  logic [31:0] head_a_o;
  logic [31:0] head_b_o;
  logic        deq_i = 1'b0;
  logic        clr_i = 1'b0;
  logic [4:0]  srch_key_i = '0;
  logic        srch_hit_o;

  int n_chk = 0;
  int n_err = 0;

  localparam logic [1:0] KADD = 2'd0, KBZ = 2'd1, KLD = 2'd2, KST = 2'd3;

  always #(CLK_P/2) clk_i = ~clk_i;

  srch_fifo dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    enq_vld_i = 1'b0; deq_i = 1'b0; clr_i = 1'b0;
  endtask

  task automatic cyc();
    @(posedge clk_i); #2; idle(); #1;
  endtask

  task automatic set_enq(input logic [1:0] k, input logic [4:0] rd, input logic [31:0] a, input logic [31:0] b);
    enq_vld_i = 1'b1; enq_kind_i = k; enq_rd_i = rd; enq_a_i = a; enq_b_i = b;
  endtask

  task automatic push(input logic [1:0] k, input logic [4:0] rd, input logic [31:0] a, input logic [31:0] b);
    set_enq(k, rd, a, b); #1; cyc();
  endtask

  task automatic pop();
    deq_i = 1'b1; #1; cyc();
  endtask

  task automatic hit_is(input logic [4:0] key, input bit exp, input string req);
    srch_key_i = key; #1;
    chk(srch_hit_o === exp, req, srch_hit_o, exp);
  endtask

  task automatic head_is(input logic [1:0] k, input logic [4:0] rd, input logic [31:0] a, input logic [31:0] b, input string req);
    chk(head_vld_o === 1'b1 && head_kind_o === k && head_rd_o === rd
        && head_a_o === a && head_b_o === b, req,
        {head_kind_o, head_rd_o, head_a_o[15:0], head_b_o[15:0]}, {k, rd, a[15:0], b[15:0]});
  endtask

  task automatic t_reset();
    chk(head_vld_o === 1'b0, "R1 empty", head_vld_o, 0);
    chk(enq_rdy_o === 1'b1, "R1 ready", enq_rdy_o, 1);
    hit_is(5'd0, 1'b0, "R1 key0");
    hit_is(5'd31, 1'b0, "R1 key31");
  endtask

  task automatic t_order();
    push(KADD, 5'd3, 32'h1, 32'h2);
    push(KLD, 5'd7, 32'h0, 32'h100);
    chk(enq_rdy_o === 1'b0, "R2 full", enq_rdy_o, 0);
    head_is(KADD, 5'd3, 32'h1, 32'h2, "R3 add head");
    hit_is(5'd3, 1'b1, "R4 add hit");
    hit_is(5'd7, 1'b1, "R4 load hit");
    hit_is(5'd5, 1'b0, "R4 miss");
    pop();
    head_is(KLD, 5'd7, 32'h0, 32'h100, "R2 second");
    pop();
    chk(head_vld_o === 1'b0, "R2 drained", head_vld_o, 0);
  endtask

  task automatic t_nomatch();
    push(KBZ, 5'd9, 32'h0, 32'h40);
    push(KST, 5'd9, 32'hdead, 32'h80);
    hit_is(5'd9, 1'b0, "R5 bz/store");
    head_is(KBZ, 5'd9, 32'h0, 32'h40, "R3 bz head");
    clr_i = 1'b1; #1; cyc();
    chk(head_vld_o === 1'b0, "R7 flushed", head_vld_o, 0);
  endtask

  task automatic t_deq_search();
    push(KADD, 5'd4, 32'h5, 32'h6);
    push(KLD, 5'd6, 32'h0, 32'h200);
    deq_i = 1'b1;
    hit_is(5'd4, 1'b0, "R6 head excluded");
    hit_is(5'd6, 1'b1, "R6 rest seen");
    cyc();
    head_is(KLD, 5'd6, 32'h0, 32'h200, "R6 after deq");
  endtask

  task automatic t_full_deq_enq();
    push(KST, 5'd1, 32'h77, 32'h300);
    chk(enq_rdy_o === 1'b0, "R8 full", enq_rdy_o, 0);
    deq_i = 1'b1; set_enq(KADD, 5'd12, 32'h8, 32'h9); #1;
    chk(enq_rdy_o === 1'b1, "R8 ready on deq", enq_rdy_o, 1);
    cyc();
    head_is(KST, 5'd1, 32'h77, 32'h300, "R8 order 1");
    pop();
    head_is(KADD, 5'd12, 32'h8, 32'h9, "R8 order 2");
    pop();
    chk(head_vld_o === 1'b0, "R8 drained", head_vld_o, 0);
  endtask

  task automatic t_clear_search();
    push(KADD, 5'd2, 32'h1, 32'h1);
    push(KADD, 5'd8, 32'h1, 32'h1);
    clr_i = 1'b1;
    hit_is(5'd2, 1'b0, "R7 no hit in clear cycle");
    cyc();
    chk(head_vld_o === 1'b0, "R7 empty after", head_vld_o, 0);
  endtask

  task automatic t_clear_enq();
    push(KADD, 5'd1, 32'h1, 32'h1);
    clr_i = 1'b1; set_enq(KADD, 5'd10, 32'haa, 32'hbb);
    hit_is(5'd10, 1'b0, "R11 incoming unseen");
    chk(enq_rdy_o === 1'b1, "R9 ready", enq_rdy_o, 1);
    cyc();
    head_is(KADD, 5'd10, 32'haa, 32'hbb, "R9 kept");
    hit_is(5'd1, 1'b0, "R9 old gone");
    pop();
    chk(head_vld_o === 1'b0, "R9 single entry", head_vld_o, 0);
  endtask

  task automatic t_enq_visibility();
    set_enq(KLD, 5'd15, 32'h0, 32'h44);
    hit_is(5'd15, 1'b0, "R11 same cycle");
    cyc();
    hit_is(5'd15, 1'b1, "R11 next cycle");
    pop();
  endtask

  task automatic t_ignore();
    pop();
    chk(head_vld_o === 1'b0, "R10 deq empty", head_vld_o, 0);
    chk(enq_rdy_o === 1'b1, "R10 still ready", enq_rdy_o, 1);
    push(KADD, 5'd21, 32'h1, 32'h2);
    push(KADD, 5'd22, 32'h3, 32'h4);
    push(KADD, 5'd20, 32'h5, 32'h6);
    hit_is(5'd20, 1'b0, "R10 rejected enq");
    head_is(KADD, 5'd21, 32'h1, 32'h2, "R10 head kept");
    pop();
    head_is(KADD, 5'd22, 32'h3, 32'h4, "R10 second kept");
    pop();
    chk(head_vld_o === 1'b0, "R10 nothing extra", head_vld_o, 0);
  endtask

  initial begin
    #(CLK_P * 5000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 3ns);
    rst_ni = 1'b1;
    @(posedge clk_i); #3;
    t_reset();
    t_order();
    t_nomatch();
    t_deq_search();
    t_full_deq_enq();
    t_clear_search();
    t_clear_enq();
    t_enq_visibility();
    t_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule